// File: doc/BRIEF.md
# Composite Memory Select Generator

This block derives one extra active-low chip select, the composite select, from the four per-space selects of a memory bus: program, data, byte and I/O. A software-written enable mask chooses which of the four spaces the composite select answers to. When any enabled space select goes low, the composite select goes low in the same cycle. The composite path is pure combinational logic from the select inputs, so it keeps the timing of the individual selects. While the bus is granted away and the memory strobes are three-stated, the composite select is held inactive.

The block also gates the byte-space select. A disable bit lets software silence that select after booting. A boot memory wired to the byte select is then left alone, and a second memory on the composite select, enabled for byte space, can take over its addresses. While the strobes are three-stated, the byte select still follows its raw input whatever the disable bit holds.

The two control words are written through a simple synchronous write port. Each write takes effect at the next rising clock edge. The words can be read back combinationally. This block has no data stream, so all of its pins are plain control and status pins with no valid/ready handshake.

Top module: `msel_combiner`

## Requirements
- R1: When the bus is not three-stated and a select input whose enable bit is 1 is low, `comp_sel_n` is low in the same cycle, with no clock edge in between.
- R2: When the bus is not three-stated and no enabled select input is low, `comp_sel_n` is high, even if select inputs whose enable bit is 0 are low.
- R3: After reset the mask word reads 0x0B00: program, data and I/O are enabled and byte is disabled.
- R4: After reset the byte-disable bit is 0, and `byte_sel_n` equals `sel_byte_n`.
- R5: With the byte-disable bit at 1 and `bus_tristate` low, `byte_sel_n` is held high.
- R6: While `bus_tristate` is high, `byte_sel_n` equals `sel_byte_n` whatever the byte-disable bit holds.
- R7: While `bus_tristate` is high, `comp_sel_n` is high.
- R8: A write to address 0x3FE6 loads the enable mask from data bits 11 (I/O), 10 (byte), 9 (data) and 8 (program). The new mask governs `comp_sel_n` from the cycle after the write edge.
- R9: A write to address 0x3FFF loads the byte-disable bit from data bit 3. In both control words, all other bits read back as 0 and ignore written values.
- R10: Writes to any other address change neither word, and reads of any other address return 0.
- R11: The composite select answers to the raw byte select input. When byte space is enabled in the mask, this holds even while the byte-disable bit suppresses `byte_sel_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 14 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 14 | Register read address |
| rd_data | output | 16 | Combinational read data |
| sel_prog_n | input | 1 | Program-space select, active low |
| sel_data_n | input | 1 | Data-space select, active low |
| sel_byte_n | input | 1 | Raw byte-space select, active low |
| sel_io_n | input | 1 | I/O-space select, active low |
| bus_tristate | input | 1 | High while the memory strobes are three-stated for a bus grant |
| comp_sel_n | output | 1 | Composite select, active low |
| byte_sel_n | output | 1 | Gated byte-space select, active low |

## Verification
Two functions can fall in the same cycle. One is a bus three-state arriving while the byte-disable bit is set. The bench sweeps every mask value, both disable values, both three-state levels and all sixteen select patterns, and compares both outputs with values it computes from the mask arithmetic. The other is a mask write landing while an affected select is already low. The bench holds the program select low, writes the mask, and samples `comp_sel_n` just before and just after the write edge. The output must switch exactly at that edge.

// File: rtl/msel_pkg.sv
package msel_pkg;
  localparam int unsigned NUM_SEL = 4;
  // select vector bit positions, matching the mask field order
  localparam int unsigned IDX_PROG = 0;
  localparam int unsigned IDX_DATA = 1;
  localparam int unsigned IDX_BYTE = 2;
  localparam int unsigned IDX_IO   = 3;
  typedef logic [NUM_SEL-1:0] sel_vec_t;
endpackage

// File: rtl/msel_ctrl_regs.sv
module msel_ctrl_regs
  import msel_pkg::*;
#(
  parameter int unsigned ADDR_W    = 14,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned MASK_ADDR = 'h3FE6,
  parameter int unsigned SYS_ADDR  = 'h3FFF,
  parameter int unsigned MASK_LSB  = 8,
  parameter int unsigned BDIS_BIT  = 3,
  parameter int unsigned MASK_RST  = 'hB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output sel_vec_t          en_mask,
  output logic              byte_dis
);
  localparam logic [ADDR_W-1:0] MASK_A = ADDR_W'(MASK_ADDR);
  localparam logic [ADDR_W-1:0] SYS_A  = ADDR_W'(SYS_ADDR);
  localparam sel_vec_t          MASK_R = NUM_SEL'(MASK_RST);

  logic wr_mask, wr_sys;
  assign wr_mask = wr_en && (wr_addr == MASK_A);
  assign wr_sys  = wr_en && (wr_addr == SYS_A);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_mask  <= MASK_R;
      byte_dis <= 1'b0;
    end else begin
      if (wr_mask) en_mask  <= wr_data[MASK_LSB +: NUM_SEL];
      if (wr_sys)  byte_dis <= wr_data[BDIS_BIT];
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == MASK_A) rd_data[MASK_LSB +: NUM_SEL] = en_mask;
    else if (rd_addr == SYS_A) rd_data[BDIS_BIT] = byte_dis;
  end
endmodule

// File: rtl/msel_combine.sv
module msel_combine
  import msel_pkg::*;
(
  input  sel_vec_t sel_n,
  input  sel_vec_t en_mask,
  input  logic     bus_tristate,
  output logic     comp_sel_n
);
  sel_vec_t hit;
  for (genvar g = 0; g < NUM_SEL; g++) begin : g_hit
    assign hit[g] = en_mask[g] & ~sel_n[g];
  end
  assign comp_sel_n = bus_tristate | ~(|hit);
endmodule

// File: rtl/msel_byte_gate.sv
module msel_byte_gate (
  input  logic raw_n,
  input  logic byte_dis,
  input  logic bus_tristate,
  output logic gated_n
);
  // suppression only applies while this device owns the strobes
  assign gated_n = (byte_dis && !bus_tristate) ? 1'b1 : raw_n;
endmodule

// File: rtl/msel_combiner.sv
module msel_combiner
  import msel_pkg::*;
#(
  parameter int unsigned ADDR_W    = 14,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned MASK_ADDR = 'h3FE6,
  parameter int unsigned SYS_ADDR  = 'h3FFF,
  parameter int unsigned MASK_LSB  = 8,
  parameter int unsigned BDIS_BIT  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              sel_prog_n,
  input  logic              sel_data_n,
  input  logic              sel_byte_n,
  input  logic              sel_io_n,
  input  logic              bus_tristate,
  output logic              comp_sel_n,
  output logic              byte_sel_n
);
  localparam int unsigned MASK_RST = (1 << IDX_PROG) | (1 << IDX_DATA) | (1 << IDX_IO);

  sel_vec_t sel_n;
  sel_vec_t en_mask;
  logic     byte_dis;

  always_comb begin
    sel_n           = '1;
    sel_n[IDX_PROG] = sel_prog_n;
    sel_n[IDX_DATA] = sel_data_n;
    sel_n[IDX_BYTE] = sel_byte_n;
    sel_n[IDX_IO]   = sel_io_n;
  end

  msel_ctrl_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MASK_ADDR(MASK_ADDR), .SYS_ADDR(SYS_ADDR),
    .MASK_LSB(MASK_LSB), .BDIS_BIT(BDIS_BIT), .MASK_RST(MASK_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .en_mask(en_mask), .byte_dis(byte_dis)
  );

  msel_combine u_comb (
    .sel_n(sel_n), .en_mask(en_mask), .bus_tristate(bus_tristate), .comp_sel_n(comp_sel_n)
  );

  msel_byte_gate u_bgate (
    .raw_n(sel_byte_n), .byte_dis(byte_dis), .bus_tristate(bus_tristate), .gated_n(byte_sel_n)
  );
endmodule

// File: rtl/msel_checker.sv
module msel_checker #(
  parameter int unsigned ADDR_W    = 14,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned MASK_ADDR = 'h3FE6,
  parameter int unsigned MASK_LSB  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [3:0]        sel_n,
  input logic [3:0]        en_mask,
  input logic              byte_dis,
  input logic              bus_tristate,
  input logic              comp_sel_n,
  input logic              byte_sel_n
);
  AST_HIT_ASSERTS: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_tristate && ((en_mask & ~sel_n) != 4'b0)) |-> !comp_sel_n); // R1
  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_tristate && ((en_mask & ~sel_n) == 4'b0)) |-> comp_sel_n); // R2
  AST_BYTE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_dis |-> (byte_sel_n == sel_n[2])); // R4
  AST_BYTE_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_dis && !bus_tristate) |-> byte_sel_n); // R5
  AST_TRI_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_tristate |-> (byte_sel_n == sel_n[2])); // R6
  AST_TRI_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_tristate |-> comp_sel_n); // R7
  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_W'(MASK_ADDR)) |=> (en_mask == $past(wr_data[MASK_LSB +: 4]))); // R8
endmodule

bind msel_combiner msel_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MASK_ADDR(MASK_ADDR), .MASK_LSB(MASK_LSB)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .sel_n({sel_io_n, sel_byte_n, sel_data_n, sel_prog_n}), .en_mask(en_mask),
  .byte_dis(byte_dis), .bus_tristate(bus_tristate),
  .comp_sel_n(comp_sel_n), .byte_sel_n(byte_sel_n)
);

// File: tb/test_msel_combiner.sv
`timescale 1ns/1ps
module test_msel_combiner;
  localparam logic [13:0] A_MASK = 14'h3FE6;
  localparam logic [13:0] A_SYS  = 14'h3FFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [13:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [13:0] rd_addr = '0;
  logic [15:0] rd_data;
  logic        sel_prog_n = 1'b1, sel_data_n = 1'b1, sel_byte_n = 1'b1, sel_io_n = 1'b1;
  logic        bus_tristate = 1'b0;
  logic        comp_sel_n, byte_sel_n;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  msel_combiner i_msel_combiner (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .sel_prog_n(sel_prog_n), .sel_data_n(sel_data_n),
    .sel_byte_n(sel_byte_n), .sel_io_n(sel_io_n), .bus_tristate(bus_tristate),
    .comp_sel_n(comp_sel_n), .byte_sel_n(byte_sel_n)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%h expected 0x%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [13:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic rd(input logic [13:0] a, output logic [15:0] d);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  task automatic drive_sel(input logic [3:0] s);
    {sel_io_n, sel_byte_n, sel_data_n, sel_prog_n} = s;
  endtask

  initial begin
    logic [15:0] v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);

    // reset state
    rd(A_MASK, v); chk("R3", v, 16'h0B00);
    rd(A_SYS, v);  chk("R4", v, 16'h0000);
    drive_sel(4'b1011); #1 chk("R4", {15'b0, byte_sel_n}, 16'h0000);
    chk("R2", {15'b0, comp_sel_n}, 16'h0001); // byte not in reset mask
    drive_sel(4'b1110); #1 chk("R1", {15'b0, comp_sel_n}, 16'h0000);
    drive_sel(4'b1111);

    // other addresses ignored
    wr(14'h3FE7, 16'hFFFF);
    wr(14'h0000, 16'hFFFF);
    rd(A_MASK, v); chk("R10", v, 16'h0B00);
    rd(A_SYS, v);  chk("R10", v, 16'h0000);
    rd(14'h3FE7, v); chk("R10", v, 16'h0000);

    // mask write timed against a held select
    wr(A_MASK, 16'h0000);
    @(negedge clk); drive_sel(4'b1110);
    wr_en = 1'b1; wr_addr = A_MASK; wr_data = 16'h0100;
    #1 chk("R8", {15'b0, comp_sel_n}, 16'h0001); // before edge: old mask
    @(posedge clk); #1 wr_en = 1'b0;
    chk("R8", {15'b0, comp_sel_n}, 16'h0000);      // after edge: new mask
    drive_sel(4'b1111);

    // byte swap: raw byte request reaches composite while byte select is blocked
    wr(A_MASK, 16'h0400); wr(A_SYS, 16'h0008);
    @(negedge clk); drive_sel(4'b1011);
    #1 chk("R11", {14'b0, comp_sel_n, byte_sel_n}, 16'h0001);
    drive_sel(4'b1111);

    // exhaustive sweep; reserved bits written as ones
    for (int m = 0; m < 16; m++) begin
      wr(A_MASK, 16'hF0FF | (16'(m) << 8));
      rd(A_MASK, v); chk("R9", v, 16'(m) << 8);
      for (int bd = 0; bd < 2; bd++) begin
        wr(A_SYS, 16'hFFF7 | (16'(bd) << 3));
        rd(A_SYS, v); chk("R9", v, 16'(bd) << 3);
        for (int ts = 0; ts < 2; ts++) begin
          for (int s = 0; s < 16; s++) begin
            logic [3:0] sv, mv;
            logic exp_c, exp_b;
            sv = 4'(s); mv = 4'(m);
            @(negedge clk);
            drive_sel(sv); bus_tristate = ts[0];
            exp_c = ts[0] ? 1'b1 : ~|(mv & ~sv);
            exp_b = (bd[0] && !ts[0]) ? 1'b1 : sv[2];
            #1;
            if (ts != 0) chk("R7", {15'b0, comp_sel_n}, {15'b0, exp_c});
            else if (exp_c) chk("R2", {15'b0, comp_sel_n}, {15'b0, exp_c});
            else chk("R1", {15'b0, comp_sel_n}, {15'b0, exp_c});
            if (ts != 0) chk("R6", {15'b0, byte_sel_n}, {15'b0, exp_b});
            else if (bd != 0) chk("R5", {15'b0, byte_sel_n}, {15'b0, exp_b});
            else chk("R4", {15'b0, byte_sel_n}, {15'b0, exp_b});
          end
        end
        bus_tristate = 1'b0; drive_sel(4'b1111);
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule